// File: doc/BRIEF.md
# Averaging ADC Conversion Sequencer

This block is the digital control core of an analog-to-digital converter controller. It has four conversion slots (A, B, C, D, indices 0 to 3). Each slot holds a small configuration: an enable, a one-shot flag, an averaging flag, a 4-bit physical input number (one of sixteen) and a 2-bit averaging length. When the converter is switched on and at least one slot is enabled, the sequencer picks a slot and runs one conversion for it. It issues sample strobes at a rate set by a timer word, gathers the 12-bit samples returned by the analog converter, and averages a power-of-two number of them. It then posts one 12-bit result, tagged with the slot index.

The analog macro sits outside the block. It sees a one-cycle strobe plus the input number, and it answers later with a valid pulse and a sample. If no answer comes within a programmable number of cycles, the slot reports a timeout instead of a result. Slots with the one-shot flag drop their own enable once they have finished. The other slots keep running, and the enabled slots share the converter in rotating order.

Top module: `adc_avg_seq`

## Requirements
- R1: After reset all slot enables read 0, and `smp_req`, `done_vld` and `tmo_vld` are 0.
- R2: Within one conversion, successive sample strobes are spaced exactly D*(U+1)*6 clock cycles apart. D is 4<<`tmr_cfg[31:29]` (codes 6 and 7 act as 5, so D=128), and U is `tmr_cfg[UNIT_W-1:0]`. Each strobe lasts one cycle.
- R3: When averaging is on (word 1 bit 29), a conversion takes exactly N samples, with N = 4<<`word2[13:12]` (0→4, 1→8, 2→16, 3→32). `done_data` is then the 17-bit sum of those samples shifted right by log2(N).
- R4: When averaging is off, a conversion takes one sample and `done_data` equals that sample. The averaging length field is ignored.
- R5: A finished conversion raises `done_vld` for one cycle with the slot index on `done_slot`. If the slot's one-shot flag (word 1 bit 30) is set, its enable (word 1 bit 31) reads 0 from the next cycle on.
- R6: A slot whose one-shot flag is clear starts again after each result. Enabled slots are served one whole conversion per turn, in the order A, B, C, D, A, and so on. After reset, A is first.
- R7: No sample strobe is issued while `glb_cfg[0]` is 0, `glb_cfg[1]` is 1 or `glb_cfg[31]` is 1. A held slot keeps its enable and converts once the gating is lifted.
- R8: Writing 0 to a slot's enable stops it. Any conversion in progress is dropped with no result, and no further strobes are issued for that slot.
- R9: If no sample returns within `tmo_limit` cycles of a strobe, `tmo_vld` pulses with the slot on `tmo_slot`. No result is posted and the slot's enable clears.
- R10: When a host write to a slot's word 1 lands in the same cycle as that slot's self-clear, the written value is kept.
- R11: Each strobe carries, on `smp_ch`, the input number held in word 1 bits 27:24 of the slot being converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_cfg | input | 32 | Converter control word: bit 0 on, bit 1 power-down, bit 31 clock-down |
| tmr_cfg | input | 32 | Rate word: bits 31:29 pre-divider code, low UNIT_W bits core time unit |
| cfg_wr | input | 1 | Slot configuration write strobe |
| cfg_slot | input | 2 | Slot addressed by the write |
| cfg_word | input | 1 | 0 selects word 1, 1 selects word 2 |
| cfg_wdata | input | 32 | Write data |
| tmo_limit | input | TMO_W | Cycles allowed for a sample to return |
| smp_req | output | 1 | One-cycle sample strobe to the analog converter |
| smp_ch | output | 4 | Physical input number for the strobe |
| smp_vld | input | 1 | Sample returned |
| smp_data | input | 12 | Returned sample |
| done_vld | output | 1 | Result pulse |
| done_slot | output | 2 | Slot of the result |
| done_data | output | 12 | Averaged result |
| tmo_vld | output | 1 | Timeout pulse |
| tmo_slot | output | 2 | Slot that timed out |
| slot_en | output | 4 | Current enable of each slot |

## Verification
Two paths can change a slot's enable in the same cycle: the one-shot self-clear, which happens when the final sample is taken, and a host write to word 1. The bench provokes the collision by having its converter model drive the write in the same cycle as the last `smp_vld` for a one-shot slot. The write re-enables the slot. The test passes when `slot_en` stays high and a second result arrives, and fails if the enable drops. Arithmetic sweeps cover every averaging length and a set of pre-divider and unit pairs, with expected results and strobe spacing computed from the sums and formulas.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NSLOT  = 4;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int SMP_W  = 12;
  localparam int CH_W   = 4;
  localparam int CNT_W  = 6;
  localparam int ACC_W  = SMP_W + 5;

  // samples per conversion
  function automatic logic [CNT_W-1:0] avg_len(input logic avg_on, input logic [1:0] code);
    return avg_on ? (CNT_W'(4) << code) : CNT_W'(1);
  endfunction

  // log2 of samples per conversion
  function automatic logic [2:0] avg_shift(input logic avg_on, input logic [1:0] code);
    return avg_on ? (3'd2 + {1'b0, code}) : 3'd0;
  endfunction

  // clock cycles between two sample strobes
  function automatic int unsigned pace_cycles(input logic [2:0] div_code, input int unsigned unit);
    logic [2:0] d;
    d = (div_code > 3'd5) ? 3'd5 : div_code;
    return (32'd4 << d) * (unit + 32'd1) * 32'd6;
  endfunction
endpackage

// File: rtl/adc_rr_pick.sv
module adc_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] pick,
  output logic          any
);
  logic [IW-1:0] idx;

  // lowest offset after the last served slot wins; N must be a power of two
  always_comb begin
    pick = last;
    idx  = last;
    any  = |req;
    for (int k = N; k >= 1; k--) begin
      idx = IW'(last + IW'(k));
      if (req[idx]) pick = idx;
    end
  end
endmodule

// File: rtl/adc_pace_timer.sv
module adc_pace_timer #(
  parameter int UNIT_W = 8,
  parameter int PER_W  = UNIT_W + 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [2:0]        div_code,
  input  logic [UNIT_W-1:0] unit,
  output logic              tick
);
  import adc_seq_pkg::*;

  logic [PER_W-1:0] period;
  logic [PER_W-1:0] cnt;
  logic             wrap;

  assign period = PER_W'(pace_cycles(div_code, 32'(unit)));
  assign wrap   = (cnt == period - PER_W'(1));
  assign tick   = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (wrap)  cnt <= '0;
    else            cnt <= cnt + PER_W'(1);
  end
endmodule

// File: rtl/adc_avg_engine.sv
module adc_avg_engine #(
  parameter int TMO_W = 16
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           conv_on,
  input  logic [adc_seq_pkg::NSLOT-1:0]                  en,
  input  logic [adc_seq_pkg::NSLOT-1:0]                  one_shot,
  input  logic [adc_seq_pkg::NSLOT-1:0]                  avg_on,
  input  logic [adc_seq_pkg::NSLOT-1:0][1:0]             avg_code,
  input  logic [adc_seq_pkg::NSLOT-1:0][adc_seq_pkg::CH_W-1:0] chan,
  input  logic                                           tick,
  input  logic [TMO_W-1:0]                               tmo_limit,
  input  logic                                           smp_vld,
  input  logic [adc_seq_pkg::SMP_W-1:0]                  smp_data,
  output logic                                           busy,
  output logic                                           smp_req,
  output logic [adc_seq_pkg::CH_W-1:0]                   smp_ch,
  output logic                                           done_vld,
  output logic [adc_seq_pkg::SLOT_W-1:0]                 done_slot,
  output logic [adc_seq_pkg::SMP_W-1:0]                  done_data,
  output logic                                           tmo_vld,
  output logic [adc_seq_pkg::SLOT_W-1:0]                 tmo_slot,
  output logic [adc_seq_pkg::NSLOT-1:0]                  clr,
  output logic                                           last_hit,
  output logic                                           tmo_hit
);
  import adc_seq_pkg::*;

  logic [SLOT_W-1:0] cur, rr_last, pick;
  logic              any, start, live, waiting, shot_q;
  logic [CNT_W-1:0]  cnt, need;
  logic [2:0]        shift;
  logic [ACC_W-1:0]  acc, acc_nx;
  logic [TMO_W-1:0]  tmo_cnt;

  adc_rr_pick #(.N(NSLOT), .IW(SLOT_W)) u_pick (
    .req(en), .last(rr_last), .pick(pick), .any(any)
  );

  always_comb begin
    start    = !busy && conv_on && any;
    live     = busy && conv_on && en[cur];
    acc_nx   = acc + ACC_W'(smp_data);
    last_hit = live && waiting && smp_vld && (cnt + CNT_W'(1) == need);
    tmo_hit  = live && waiting && !smp_vld && (tmo_cnt == tmo_limit - TMO_W'(1));
    clr      = '0;
    if ((last_hit && shot_q) || tmo_hit) clr[cur] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; waiting <= 1'b0; shot_q <= 1'b0;
      cur <= '0; rr_last <= SLOT_W'(NSLOT - 1);
      cnt <= '0; need <= '0; shift <= '0; acc <= '0; tmo_cnt <= '0;
      smp_req <= 1'b0; smp_ch <= '0;
      done_vld <= 1'b0; done_slot <= '0; done_data <= '0;
      tmo_vld <= 1'b0; tmo_slot <= '0;
    end else begin
      smp_req  <= 1'b0;
      done_vld <= 1'b0;
      tmo_vld  <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        waiting <= 1'b0;
        cur     <= pick;
        rr_last <= pick;
        cnt     <= '0;
        acc     <= '0;
        need    <= avg_len(avg_on[pick], avg_code[pick]);
        shift   <= avg_shift(avg_on[pick], avg_code[pick]);
        shot_q  <= one_shot[pick];
        smp_ch  <= chan[pick];
      end else if (busy) begin
        if (!live) begin
          busy    <= 1'b0;
          waiting <= 1'b0;
        end else if (waiting) begin
          if (smp_vld) begin
            acc     <= acc_nx;
            cnt     <= cnt + CNT_W'(1);
            waiting <= 1'b0;
            if (last_hit) begin
              busy      <= 1'b0;
              done_vld  <= 1'b1;
              done_slot <= cur;
              done_data <= SMP_W'(acc_nx >> shift);
            end
          end else if (tmo_hit) begin
            busy     <= 1'b0;
            waiting  <= 1'b0;
            tmo_vld  <= 1'b1;
            tmo_slot <= cur;
          end else begin
            tmo_cnt <= tmo_cnt + TMO_W'(1);
          end
        end else if (tick) begin
          smp_req <= 1'b1;
          waiting <= 1'b1;
          tmo_cnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/adc_avg_seq.sv
module adc_avg_seq #(
  parameter int UNIT_W = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       glb_cfg,
  input  logic [31:0]       tmr_cfg,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_slot,
  input  logic              cfg_word,
  input  logic [31:0]       cfg_wdata,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              smp_req,
  output logic [3:0]        smp_ch,
  input  logic              smp_vld,
  input  logic [11:0]       smp_data,
  output logic              done_vld,
  output logic [1:0]        done_slot,
  output logic [11:0]       done_data,
  output logic              tmo_vld,
  output logic [1:0]        tmo_slot,
  output logic [3:0]        slot_en
);
  import adc_seq_pkg::*;

  localparam int PER_W = UNIT_W + 10;

  logic                        conv_on, eng_busy, pace_tick, last_hit, tmo_hit;
  logic [NSLOT-1:0]            slot_clr, shot_v, avg_v;
  logic [NSLOT-1:0][1:0]       code_v;
  logic [NSLOT-1:0][CH_W-1:0]  chan_v;
  logic                        unused_bits;

  assign conv_on     = glb_cfg[0] && !glb_cfg[1] && !glb_cfg[31];
  assign unused_bits = ^{glb_cfg[30:2], tmr_cfg[28:UNIT_W], cfg_wdata[28],
                         cfg_wdata[23:14], cfg_wdata[11:0]};

  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
    logic            en_q, shot_q, avg_q;
    logic [1:0]      code_q;
    logic [CH_W-1:0] chan_q;
    logic            hit, wr1, wr2;

    assign hit = cfg_wr && (cfg_slot == SLOT_W'(gi));
    assign wr1 = hit && !cfg_word;
    assign wr2 = hit && cfg_word;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b0; shot_q <= 1'b0; avg_q <= 1'b0; chan_q <= '0; code_q <= '0;
      end else begin
        if (wr1) begin
          en_q   <= cfg_wdata[31];
          shot_q <= cfg_wdata[30];
          avg_q  <= cfg_wdata[29];
          chan_q <= cfg_wdata[27:24];
        end else if (slot_clr[gi]) begin
          en_q <= 1'b0;
        end
        if (wr2) code_q <= cfg_wdata[13:12];
      end
    end

    assign slot_en[gi] = en_q;
    assign shot_v[gi]  = shot_q;
    assign avg_v[gi]   = avg_q;
    assign code_v[gi]  = code_q;
    assign chan_v[gi]  = chan_q;
  end

  adc_pace_timer #(.UNIT_W(UNIT_W), .PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(eng_busy),
    .div_code(tmr_cfg[31:29]), .unit(tmr_cfg[UNIT_W-1:0]), .tick(pace_tick)
  );

  adc_avg_engine #(.TMO_W(TMO_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .conv_on(conv_on),
    .en(slot_en), .one_shot(shot_v), .avg_on(avg_v), .avg_code(code_v), .chan(chan_v),
    .tick(pace_tick), .tmo_limit(tmo_limit), .smp_vld(smp_vld), .smp_data(smp_data),
    .busy(eng_busy), .smp_req(smp_req), .smp_ch(smp_ch),
    .done_vld(done_vld), .done_slot(done_slot), .done_data(done_data),
    .tmo_vld(tmo_vld), .tmo_slot(tmo_slot), .clr(slot_clr),
    .last_hit(last_hit), .tmo_hit(tmo_hit)
  );
endmodule

// File: rtl/adc_avg_seq_chk.sv
module adc_avg_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] glb_cfg,
  input logic        cfg_wr,
  input logic [1:0]  cfg_slot,
  input logic        cfg_word,
  input logic [31:0] cfg_wdata,
  input logic        smp_req,
  input logic        smp_vld,
  input logic        done_vld,
  input logic        tmo_vld,
  input logic [1:0]  tmo_slot,
  input logic [3:0]  slot_en,
  input logic        pace_tick,
  input logic        eng_busy
);
  p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |=> !smp_req);

  p_strobe_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |-> $past(pace_tick && eng_busy));

  p_sum_after_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |-> $past(smp_vld));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |=> !done_vld);

  p_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |-> $past(glb_cfg[0] && !glb_cfg[1] && !glb_cfg[31]));

  p_tmo_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_vld && tmo_vld));

  p_tmo_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_vld |-> (!slot_en[tmo_slot] || $past(cfg_wr && !cfg_word && cfg_slot == tmo_slot)));

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr && !cfg_word) |-> (slot_en[$past(cfg_slot)] == $past(cfg_wdata[31])));
endmodule

bind adc_avg_seq adc_avg_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .glb_cfg(glb_cfg), .cfg_wr(cfg_wr), .cfg_slot(cfg_slot),
  .cfg_word(cfg_word), .cfg_wdata(cfg_wdata), .smp_req(smp_req), .smp_vld(smp_vld),
  .done_vld(done_vld), .tmo_vld(tmo_vld), .tmo_slot(tmo_slot), .slot_en(slot_en),
  .pace_tick(pace_tick), .eng_busy(eng_busy)
);

// File: tb/adc_avg_seq_tb_top.sv
`timescale 1ns/1ps
module adc_avg_seq_tb_top;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] glb_cfg = 32'd0;
  logic [31:0] tmr_cfg = 32'd0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_slot = 2'd0;
  logic        cfg_word = 1'b0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [15:0] tmo_limit = 16'd100;
  logic        smp_vld = 1'b0;
  logic [11:0] smp_data = 12'd0;
  logic        smp_req, done_vld, tmo_vld;
  logic [3:0]  smp_ch, slot_en;
  logic [1:0]  done_slot, tmo_slot;
  logic [11:0] done_data;

  always #2 clk = ~clk;

  adc_avg_seq dut_i (
    .clk(clk), .rst_n(rst_n), .glb_cfg(glb_cfg), .tmr_cfg(tmr_cfg),
    .cfg_wr(cfg_wr), .cfg_slot(cfg_slot), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
    .tmo_limit(tmo_limit), .smp_req(smp_req), .smp_ch(smp_ch),
    .smp_vld(smp_vld), .smp_data(smp_data), .done_vld(done_vld),
    .done_slot(done_slot), .done_data(done_data), .tmo_vld(tmo_vld),
    .tmo_slot(tmo_slot), .slot_en(slot_en)
  );

  int    n_chk = 0, n_bad = 0, cyc = 0, tot = 0;
  int    sum_ch [16];
  int    cnt_ch [16];
  bit    ch_ok [16];
  int    slot_ch [4];
  int    slot_n [4];
  int    slot_sh [4];
  int    done_log [64];
  int    n_done = 0, n_tmo = 0, n_req = 0, last_tmo = -1;
  int    last_req_cyc = -1, last_req_ch = -1, exp_gap = 0;
  bit    gap_on = 0, resp_on = 1, collide_arm = 0, finished = 0;
  logic [31:0] collide_word = 32'd0;
  logic [1:0]  collide_slot = 2'd0;
  string data_tag = "R3";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] w1(input bit en, input bit shot, input bit avg, input int ch);
    return {en, shot, avg, 1'b0, 4'(ch), 24'd0};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      if (smp_req && resp_on) begin
        int ch, d;
        ch = int'(smp_ch);
        repeat (LAT - 1) @(negedge clk);
        d = (ch * 331 + tot * 97 + 5) & 12'hFFF;
        tot++;
        sum_ch[ch] += d;
        cnt_ch[ch]++;
        smp_data = 12'(d);
        smp_vld = 1'b1;
        if (collide_arm) begin
          cfg_wr = 1'b1; cfg_slot = collide_slot; cfg_word = 1'b0; cfg_wdata = collide_word;
          collide_arm = 0;
        end
        @(negedge clk);
        smp_vld = 1'b0;
        cfg_wr = 1'b0;
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && smp_req) begin
        n_req++;
        check(ch_ok[smp_ch], "R11 input select", int'(smp_ch), -1);
        if (gap_on && last_req_cyc >= 0 && last_req_ch == int'(smp_ch))
          check(cyc - last_req_cyc == exp_gap, "R2 strobe spacing", cyc - last_req_cyc, exp_gap);
        last_req_cyc = cyc;
        last_req_ch = int'(smp_ch);
      end
      if (rst_n && done_vld) begin
        int s, ch;
        s = int'(done_slot);
        ch = slot_ch[s];
        check(int'(done_data) == (sum_ch[ch] >> slot_sh[s]), data_tag, int'(done_data), sum_ch[ch] >> slot_sh[s]);
        check(cnt_ch[ch] == slot_n[s], {data_tag, " sample count"}, cnt_ch[ch], slot_n[s]);
        sum_ch[ch] = 0;
        cnt_ch[ch] = 0;
        if (n_done < 64) done_log[n_done] = s;
        n_done++;
        last_req_cyc = -1;
      end
      if (rst_n && tmo_vld) begin
        n_tmo++;
        last_tmo = int'(tmo_slot);
      end
    end
  end

  task automatic wr(input int slot, input bit word, input logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_slot = 2'(slot); cfg_word = word; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic clear_model();
    for (int i = 0; i < 16; i++) begin sum_ch[i] = 0; cnt_ch[i] = 0; ch_ok[i] = 0; end
  endtask

  task automatic setup_slot(input int s, input int ch, input bit shot, input bit avg, input int code);
    slot_ch[s] = ch;
    slot_n[s] = avg ? (4 << code) : 1;
    slot_sh[s] = avg ? (2 + code) : 0;
    ch_ok[ch] = 1;
    wr(s, 1'b1, 32'(code) << 12);
    wr(s, 1'b0, w1(1'b1, shot, avg, ch));
  endtask

  task automatic wait_done(input int target, input int max_cyc, input string req);
    int k;
    k = 0;
    while (n_done < target && k < max_cyc) begin @(negedge clk); k++; end
    check(n_done >= target, req, n_done, target);
  endtask

  task automatic quiet_window(input int len, input string req);
    int r0, d0;
    r0 = n_req; d0 = n_done;
    repeat (len) @(negedge clk);
    check(n_req == r0, {req, " strobes"}, n_req - r0, 0);
    check(n_done == d0, {req, " results"}, n_done - d0, 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    clear_model();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(slot_en == 4'd0, "R1 enables", int'(slot_en), 0);
    check(!smp_req && !done_vld, "R1 strobe/result", int'(smp_req) + int'(done_vld), 0);
    check(!tmo_vld, "R1 timeout", int'(tmo_vld), 0);

    glb_cfg = 32'd1;
    tmr_cfg = 32'd0;

    // R3, R5: every averaging length, one-shot, one slot each
    for (int code = 0; code < 4; code++) begin
      base = n_done;
      setup_slot(code, 3 + code * 3, 1'b1, 1'b1, code);
      wait_done(base + 1, 2000, "R3 result arrives");
      @(negedge clk);
      check(slot_en[code] == 1'b0, "R5 one-shot clear", int'(slot_en[code]), 0);
      check(n_done == base + 1, "R5 single result", n_done - base, 1);
    end

    // R4: averaging off, length field ignored
    data_tag = "R4";
    base = n_done;
    setup_slot(1, 15, 1'b1, 1'b0, 3);
    wait_done(base + 1, 500, "R4 result arrives");
    data_tag = "R3";

    // R2: strobe spacing across divider codes and units
    gap_on = 1;
    for (int v = 0; v < 10; v++) begin
      int d, u;
      d = (v < 7) ? v : 0;
      u = (v < 7) ? 0 : v - 6;
      tmr_cfg = (32'(d) << 29) | 32'(u);
      exp_gap = (4 << ((d > 5) ? 5 : d)) * (u + 1) * 6;
      base = n_done;
      setup_slot(0, 1, 1'b1, 1'b1, 0);
      wait_done(base + 1, exp_gap * 6 + 50, "R2 rate run");
    end
    gap_on = 0;
    tmr_cfg = 32'd0;

    // R6: round robin, continuous mode
    clear_model();
    base = n_done;
    setup_slot(0, 2, 1'b0, 1'b1, 0);
    setup_slot(1, 5, 1'b0, 1'b1, 0);
    setup_slot(2, 8, 1'b0, 1'b1, 0);
    setup_slot(3, 11, 1'b0, 1'b1, 0);
    wait_done(base + 8, 3000, "R6 continuous results");
    for (int i = 0; i < 8; i++)
      check(done_log[base + i] == i % 4, "R6 service order", done_log[base + i], i % 4);

    // R8: disable all mid-run
    for (int s = 0; s < 4; s++) wr(s, 1'b0, w1(1'b0, 1'b0, 1'b1, slot_ch[s]));
    check(slot_en == 4'd0, "R8 enables low", int'(slot_en), 0);
    repeat (10) @(negedge clk);
    quiet_window(400, "R8 stopped");

    // R7: gating by each control bit
    clear_model();
    glb_cfg = 32'd0;
    base = n_done;
    setup_slot(0, 6, 1'b1, 1'b1, 0);
    quiet_window(200, "R7 converter off");
    glb_cfg = 32'h0000_0003;
    quiet_window(200, "R7 power-down");
    glb_cfg = 32'h8000_0001;
    quiet_window(200, "R7 clock-down");
    check(slot_en[0] == 1'b1, "R7 enable kept", int'(slot_en[0]), 1);
    glb_cfg = 32'd1;
    wait_done(base + 1, 500, "R7 resumes");

    // R9: timeout
    resp_on = 0;
    tmo_limit = 16'd10;
    base = n_done;
    begin
      int t0;
      t0 = n_tmo;
      setup_slot(2, 7, 1'b1, 1'b1, 0);
      repeat (100) @(negedge clk);
      check(n_tmo == t0 + 1, "R9 timeout pulse", n_tmo - t0, 1);
      check(last_tmo == 2, "R9 timeout slot", last_tmo, 2);
      check(slot_en[2] == 1'b0, "R9 enable cleared", int'(slot_en[2]), 0);
      check(n_done == base, "R9 no result", n_done - base, 0);
    end
    resp_on = 1;
    tmo_limit = 16'd100;

    // R10: host write collides with self-clear
    clear_model();
    base = n_done;
    collide_slot = 2'd3;
    collide_word = w1(1'b1, 1'b1, 1'b0, 9);
    collide_arm = 1;
    setup_slot(3, 9, 1'b1, 1'b0, 0);
    wait_done(base + 1, 500, "R10 first result");
    @(negedge clk);
    check(slot_en[3] == 1'b1, "R10 write wins", int'(slot_en[3]), 1);
    wait_done(base + 2, 500, "R10 second result");
    @(negedge clk);
    check(slot_en[3] == 1'b0, "R5 one-shot after rerun", int'(slot_en[3]), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule